// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides which receive message buffer, if any, accepts an incoming CAN frame. The receiver hands over the identifier of each finished frame as a one-cycle strobe. The strobe carries three things: the 11-bit base part, the 18-bit extended part and the format flag. The block compares these against a bank of sixteen buffer descriptors. On the next clock it reports a hit pulse and the index of the accepting buffer.

Each identifier bit is compared under a mask. A mask bit of 1 makes the bit significant, and a mask bit of 0 makes it a don't-care. Buffers 0 to 13 share one global mask. Buffers 14 and 15 each have a private mask instead. This lets software give the two top buffers a wider or narrower acceptance window than the rest of the bank. A frame rejected by the global filter can still land in one of those two buffers.

Descriptors and masks are loaded through a single-cycle register write port. Bit timing, deserialisation, CRC checking and storage of the payload are handled elsewhere.

Top module: `can_acf_top`

## Requirements
- R1: After reset, every buffer descriptor is zero (disabled), every mask is all ones, the hit output is low and the index output is 0.
- R2: For each significant identifier bit (mask bit 1), the frame bit must equal the stored bit. Identifier bits whose mask bit is 0 never prevent acceptance.
- R3: A standard frame (format flag 0) is compared on the 11 base bits only, and the stored extended bits are ignored. An extended frame (format flag 1) must also pass on all 18 extended bits.
- R4: The format flag is always compared and cannot be masked. A standard buffer never accepts an extended frame, and an extended buffer never accepts a standard frame.
- R5: Buffers 0 to 13 are all compared under the global mask.
- R6: Buffer 14 is compared under its own mask only. Changes to the global mask do not alter its acceptance, and it can accept a frame that the global filter rejects.
- R7: Buffer 15 is compared under its own mask only, in the same way as buffer 14.
- R8: A buffer takes part only when both its enable bit and its receive bit are 1.
- R9: When several buffers accept a frame, the lowest-numbered one is reported.
- R10: Hit rises in the cycle after a strobe whose frame is accepted, and lasts one cycle. Hit stays low after a rejected frame and in cycles without a strobe. The index output changes only on a hit and otherwise holds its value.
- R11: A register write in the same cycle as a frame strobe does not affect that frame. It applies from the next frame on.
- R12: Write addresses and word layout:
  - Addresses 0 to 15 select the buffer descriptors. A descriptor word is enable at bit 31, receive at bit 30, format at bit 29, base identifier at bits 28:18 and extended identifier at bits 17:0.
  - Address 16 is the global mask, address 17 is the mask of buffer 14 and address 18 is the mask of buffer 15.
  - A mask word uses bits 28:18 for the base bits and bits 17:0 for the extended bits.
  - Writes to any other address are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 32 | Register write data |
| fr_vld | input | 1 | Frame identifier strobe |
| fr_base | input | 11 | Base identifier of the frame |
| fr_ext | input | 18 | Extended identifier of the frame |
| fr_ide | input | 1 | Frame format flag, 1 = extended |
| hit_q | output | 1 | Acceptance pulse, one cycle after the strobe |
| idx_q | output | 4 | Index of the accepting buffer |

## Verification
The hardest situation to reach is one where the private-mask buffers act differently from the general bank. The stimulus has to catch the same frame failing under the global mask while passing under a private one, and the reverse. The bench sets a private mask with one base bit relaxed and leaves the global mask strict. It then sends a frame differing in that bit and expects buffer 14. Next it relaxes a different bit only in the global mask and disables the lower buffer. A frame differing in that bit must then miss buffer 14, while a general buffer with the same identifier accepts it. The same-cycle write case is reached by driving a write and a strobe on the same clock edge.

// File: rtl/can_acf_pkg.sv
package can_acf_pkg;
   localparam int unsigned DEF_BASE_W = 11;
   localparam int unsigned DEF_EXT_W  = 18;
   localparam int unsigned DEF_NBUF   = 16;
   localparam int unsigned DEF_NPRIV  = 2;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_BUF  = 2'd1,
      TGT_MASK = 2'd2
   } acf_tgt_e;
endpackage

// File: rtl/can_acf_regs.sv
module can_acf_regs
   import can_acf_pkg::*;
#(
   parameter int unsigned NBUF   = DEF_NBUF,
   parameter int unsigned NMASK  = DEF_NPRIV + 1,
   parameter int unsigned ID_W   = DEF_BASE_W + DEF_EXT_W,
   parameter int unsigned WORD_W = ID_W + 3,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] buf_o  [NBUF],
   output logic [ID_W-1:0]   mask_o [NMASK]
);
   acf_tgt_e tgt;
   int unsigned addr_i;

   always_comb begin
      addr_i = int'(wr_addr);
      if (!wr_en)                     tgt = TGT_NONE;
      else if (addr_i < NBUF)         tgt = TGT_BUF;
      else if (addr_i < NBUF + NMASK) tgt = TGT_MASK;
      else                            tgt = TGT_NONE;
   end

   for (genvar b = 0; b < NBUF; b++) begin : g_buf
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             q <= '0;
         else if (tgt == TGT_BUF && addr_i == b) q <= wr_data;
      end
      assign buf_o[b] = q;

      // R11: a descriptor write is visible from the following cycle
      a_r11_buf_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && int'(wr_addr) == b) |=> (q == $past(wr_data)));
   end

   for (genvar m = 0; m < NMASK; m++) begin : g_mask
      logic [ID_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                     q <= '1;
         else if (tgt == TGT_MASK && addr_i == NBUF + m) q <= wr_data[ID_W-1:0];
      end
      assign mask_o[m] = q;
   end
endmodule

// File: rtl/can_acf_cmp.sv
module can_acf_cmp #(
   parameter int unsigned BASE_W = 11,
   parameter int unsigned EXT_W  = 18,
   parameter int unsigned ID_W   = BASE_W + EXT_W,
   parameter int unsigned WORD_W = ID_W + 3
) (
   input  logic [WORD_W-1:0] cfg_i,
   input  logic [ID_W-1:0]   mask_i,
   input  logic [BASE_W-1:0] fr_base,
   input  logic [EXT_W-1:0]  fr_ext,
   input  logic              fr_ide,
   output logic              match_o
);
   logic              en, rx, ide;
   logic [BASE_W-1:0] id_b, mk_b;
   logic [EXT_W-1:0]  id_e, mk_e;
   logic              base_ok, ext_ok;

   assign {en, rx, ide, id_b, id_e} = cfg_i;
   assign {mk_b, mk_e}              = mask_i;

   always_comb begin
      base_ok = ((fr_base ^ id_b) & mk_b) == '0;
      ext_ok  = !fr_ide || (((fr_ext ^ id_e) & mk_e) == '0);
      match_o = en && rx && (ide == fr_ide) && base_ok && ext_ok;
   end
endmodule

// File: rtl/can_acf_prio.sv
module can_acf_prio #(
   parameter int unsigned N     = 16,
   parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   logic [N-1:0] below;

   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            any_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end

   always_comb begin
      below = '0;
      for (int i = 0; i < N; i++) begin
         if (i < int'(idx_o)) below[i] = 1'b1;
      end
   end

   // R9: the reported request is set and no lower request exists
   always_comb begin
      if (any_o) begin
         a_r9_lowest_wins: assert (req_i[idx_o] && ((req_i & below) == '0));
      end
   end
endmodule

// File: rtl/can_acf_top.sv
module can_acf_top
   import can_acf_pkg::*;
#(
   parameter int unsigned NBUF   = DEF_NBUF,
   parameter int unsigned NPRIV  = DEF_NPRIV,
   parameter int unsigned BASE_W = DEF_BASE_W,
   parameter int unsigned EXT_W  = DEF_EXT_W,
   localparam int unsigned ID_W   = BASE_W + EXT_W,
   localparam int unsigned WORD_W = ID_W + 3,
   localparam int unsigned NMASK  = NPRIV + 1,
   localparam int unsigned ADDR_W = $clog2(NBUF + NMASK + 1),
   localparam int unsigned IDX_W  = $clog2(NBUF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              fr_vld,
   input  logic [BASE_W-1:0] fr_base,
   input  logic [EXT_W-1:0]  fr_ext,
   input  logic              fr_ide,
   output logic              hit_q,
   output logic [IDX_W-1:0]  idx_q
);
   if (NBUF < 2) begin : g_chk_nbuf
      $error("can_acf_top: NBUF must be at least 2");
   end
   if (NPRIV >= NBUF) begin : g_chk_npriv
      $error("can_acf_top: NPRIV must be smaller than NBUF");
   end

   localparam int unsigned FIRST_PRIV = NBUF - NPRIV;

   logic [WORD_W-1:0] buf_cfg [NBUF];
   logic [ID_W-1:0]   mask   [NMASK];
   logic [NBUF-1:0]   match_vec;
   logic              any_hit;
   logic [IDX_W-1:0]  win_idx;

   can_acf_regs #(
      .NBUF(NBUF), .NMASK(NMASK), .ID_W(ID_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .buf_o(buf_cfg), .mask_o(mask)
   );

   for (genvar k = 0; k < NBUF; k++) begin : g_slot
      logic [ID_W-1:0] sel_mask;
      if (k >= FIRST_PRIV) begin : g_priv
         assign sel_mask = mask[k - FIRST_PRIV + 1];
      end else begin : g_glob
         assign sel_mask = mask[0];
      end
      can_acf_cmp #(
         .BASE_W(BASE_W), .EXT_W(EXT_W)
      ) cmp_i (
         .cfg_i(buf_cfg[k]), .mask_i(sel_mask), .fr_base(fr_base),
         .fr_ext(fr_ext), .fr_ide(fr_ide), .match_o(match_vec[k])
      );
   end

   can_acf_prio #(.N(NBUF), .IDX_W(IDX_W)) prio_i (
      .req_i(match_vec), .any_o(any_hit), .idx_o(win_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q <= 1'b0;
         idx_q <= '0;
      end else begin
         hit_q <= fr_vld && any_hit;
         if (fr_vld && any_hit) idx_q <= win_idx;
      end
   end

   // R10: a hit only ever follows a strobe
   a_r10_hit_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      hit_q |-> $past(fr_vld));
   // R10: the index holds whenever no hit is reported
   a_r10_idx_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_q |-> $stable(idx_q));
   // R10: a hit is a single-cycle pulse unless strobes are back to back
   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_q && !$past(fr_vld, 2)) |-> !$past(hit_q));
endmodule

// File: tb/can_acf_top_tb_top.sv
module can_acf_top_tb_top;
   localparam int GM = 16, M14 = 17, M15 = 18;
   localparam logic [31:0] MFULL = 32'h1FFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        fr_vld = 1'b0;
   logic [10:0] fr_base = '0;
   logic [17:0] fr_ext = '0;
   logic        fr_ide = 1'b0;
   logic        hit_q;
   logic [3:0]  idx_q;
   int n_cmp = 0, n_bad = 0;

   always #10 clk = ~clk;

   can_acf_top dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .fr_vld(fr_vld), .fr_base(fr_base),
      .fr_ext(fr_ext), .fr_ide(fr_ide), .hit_q(hit_q), .idx_q(idx_q)
   );

   function automatic logic [31:0] bw(bit en, bit rx, bit ide,
                                      logic [10:0] b, logic [17:0] e);
      return {en, rx, ide, b, e};
   endfunction

   task automatic check(string req, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a[4:0]; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic expect_frame(string req, logic [10:0] b, logic [17:0] e,
                               bit ide, bit hit, int idx);
      @(negedge clk);
      fr_vld = 1'b1; fr_base = b; fr_ext = e; fr_ide = ide;
      @(negedge clk);
      fr_vld = 1'b0;
      check(req, "hit", int'(hit_q), int'(hit));
      if (hit) check(req, "idx", int'(idx_q), idx);
   endtask

   task automatic t_reset;
      check("R1", "hit after reset", int'(hit_q), 0);
      check("R1", "idx after reset", int'(idx_q), 0);
      expect_frame("R1", 11'h000, 18'h0, 1'b0, 1'b0, 0);
      wr(0, bw(1, 1, 0, 11'h000, 18'h0));
      expect_frame("R1", 11'h001, 18'h0, 1'b0, 1'b0, 0);
      expect_frame("R1", 11'h000, 18'h0, 1'b0, 1'b1, 0);
      wr(0, 32'h0);
   endtask

   task automatic t_mask;
      wr(2, bw(1, 1, 0, 11'h123, 18'h0));
      expect_frame("R2", 11'h123, 18'h0, 1'b0, 1'b1, 2);
      expect_frame("R2", 11'h122, 18'h0, 1'b0, 1'b0, 0);
      wr(GM, 32'h1FFB_FFFF);
      expect_frame("R5", 11'h122, 18'h0, 1'b0, 1'b1, 2);
      wr(GM, MFULL);
   endtask

   task automatic t_fields;
      wr(3, bw(1, 1, 1, 11'h0AA, 18'h15555));
      expect_frame("R3", 11'h0AA, 18'h15555, 1'b1, 1'b1, 3);
      expect_frame("R3", 11'h0AA, 18'h15554, 1'b1, 1'b0, 0);
      wr(2, bw(1, 1, 0, 11'h123, 18'h3FFFF));
      expect_frame("R3", 11'h123, 18'h00000, 1'b0, 1'b1, 2);
      expect_frame("R4", 11'h123, 18'h3FFFF, 1'b1, 1'b0, 0);
      expect_frame("R4", 11'h0AA, 18'h15555, 1'b0, 1'b0, 0);
   endtask

   task automatic t_b14;
      wr(14, bw(1, 1, 0, 11'h123, 18'h0));
      wr(M14, 32'h1FFB_FFFF);
      expect_frame("R6", 11'h122, 18'h0, 1'b0, 1'b1, 14);
      expect_frame("R12", 11'h123, 18'h0, 1'b0, 1'b1, 2);
      wr(2, 32'h0);
      wr(GM, 32'h1FF7_FFFF);
      expect_frame("R6", 11'h121, 18'h0, 1'b0, 1'b0, 0);
      wr(1, bw(1, 1, 0, 11'h123, 18'h0));
      expect_frame("R5", 11'h121, 18'h0, 1'b0, 1'b1, 1);
      wr(1, 32'h0);
      wr(GM, MFULL);
      wr(25, 32'h0000_0000);
      expect_frame("R12", 11'h122, 18'h0, 1'b0, 1'b1, 14);
   endtask

   task automatic t_b15;
      wr(15, bw(1, 1, 1, 11'h7FF, 18'h0));
      wr(M15, 32'h1FFC_0000);
      wr(4, bw(1, 1, 1, 11'h7FF, 18'h0));
      expect_frame("R7", 11'h7FF, 18'h2ABCD, 1'b1, 1'b1, 15);
      expect_frame("R9", 11'h7FF, 18'h00000, 1'b1, 1'b1, 4);
      expect_frame("R7", 11'h7FE, 18'h2ABCD, 1'b1, 1'b0, 0);
      expect_frame("R4", 11'h7FF, 18'h00000, 1'b0, 1'b0, 0);
      wr(4, 32'h0);
   endtask

   task automatic t_enable;
      wr(5, bw(1, 0, 0, 11'h055, 18'h0));
      expect_frame("R8", 11'h055, 18'h0, 1'b0, 1'b0, 0);
      wr(5, bw(0, 1, 0, 11'h055, 18'h0));
      expect_frame("R8", 11'h055, 18'h0, 1'b0, 1'b0, 0);
      wr(5, bw(1, 1, 0, 11'h055, 18'h0));
      expect_frame("R8", 11'h055, 18'h0, 1'b0, 1'b1, 5);
   endtask

   task automatic t_prio;
      wr(6, bw(1, 1, 0, 11'h055, 18'h0));
      expect_frame("R9", 11'h055, 18'h0, 1'b0, 1'b1, 5);
      wr(2, bw(1, 1, 0, 11'h055, 18'h0));
      expect_frame("R9", 11'h055, 18'h0, 1'b0, 1'b1, 2);
      wr(2, 32'h0);
      wr(5, 32'h0);
      expect_frame("R9", 11'h055, 18'h0, 1'b0, 1'b1, 6);
   endtask

   task automatic t_timing;
      expect_frame("R10", 11'h055, 18'h0, 1'b0, 1'b1, 6);
      @(negedge clk);
      check("R10", "hit one cycle later", int'(hit_q), 0);
      check("R10", "idx held", int'(idx_q), 6);
      expect_frame("R10", 11'h3FF, 18'h0, 1'b0, 1'b0, 0);
      check("R10", "idx held after miss", int'(idx_q), 6);
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      fr_vld = 1'b1; fr_base = 11'h300; fr_ext = '0; fr_ide = 1'b0;
      wr_en = 1'b1; wr_addr = 5'd7; wr_data = bw(1, 1, 0, 11'h300, 18'h0);
      @(negedge clk);
      fr_vld = 1'b0; wr_en = 1'b0;
      check("R11", "hit with new descriptor", int'(hit_q), 0);
      expect_frame("R11", 11'h300, 18'h0, 1'b0, 1'b1, 7);
      @(negedge clk);
      fr_vld = 1'b1; fr_base = 11'h300;
      wr_en = 1'b1; wr_addr = 5'd7; wr_data = 32'h0;
      @(negedge clk);
      fr_vld = 1'b0; wr_en = 1'b0;
      check("R11", "hit with old descriptor", int'(hit_q), 1);
      check("R11", "idx with old descriptor", int'(idx_q), 7);
      expect_frame("R11", 11'h300, 18'h0, 1'b0, 1'b0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask();
      t_fields();
      t_b14();
      t_b15();
      t_enable();
      t_prio();
      t_timing();
      t_same_cycle();
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule